// File: doc/BRIEF.md
# Performance Counter Access Port

This block sits between a request bus and a bank of performance counters and decides what every access does to that bank. Writes arrive by address. Each general-purpose counter can be reached through two address windows that behave differently. The legacy window takes only the low 32 bits of the write data, sign-extends them and trims the result to the counter width. The full-width window stores the value as given, but refuses any value that has bits above the counter width. A third window reaches the fixed counters. Reads can come through any window, or through a compact 32-bit counter index. In that index, one flag bit picks the fixed bank and another asks for a short 32-bit result.

The counter storage is outside the block. The port drives a read selector, which gets its data back in the same cycle, and a registered write strobe. Each request receives an acknowledge one cycle later. Illegal requests get a fault flag together with that acknowledge, and their read data is zero. A faulting request never writes. The counter widths, the number of counters of each kind and the address window layout are all parameters.

Top module: `cap_top`

## Requirements
- R1: A write to the legacy window (address bits [11:8] = 1, bits [7:0] = counter number) stores bits [31:0] of the write data, sign-extended from bit 31 and masked to the general-purpose width; bits [63:32] of the write data are ignored and never fault.
- R2: A write to the full-width window (address bits [11:8] = 2) whose value fits in the general-purpose width stores that value unchanged.
- R3: A full-width-window write whose value has any bit set at or above the general-purpose width faults and leaves the counter unchanged.
- R4: A read (op 0) through the legacy window or the full-width window at the same counter number returns the same stored value, masked to the counter width.
- R5: An index read (op 2) uses index bit 30 to select the fixed bank (1) or the general-purpose bank (0), and bits [29:0] as the counter number; it returns the stored value masked to that bank's width.
- R6: An index read with index bit 31 set returns only bits [31:0] of the counter, with bits [63:32] zero.
- R7: A fault is raised for each of the following: a counter number at or above that bank's count (by address or by index, e.g. index 64), an address outside windows 1 to 3, and the reserved op 3.
- R8: A faulting access asserts the fault flag and the acknowledge in the same cycle, returns zero read data, and does not write.
- R9: Every request held for one cycle gets exactly one acknowledge, in the next cycle. A write strobe, when there is one, comes in that same cycle.
- R10: A write to the fixed window (address bits [11:8] = 3) follows the full-width rule against the fixed width. The value it stores reads back exactly through an index read with bit 30 set.
- R11: While reset is held, the acknowledge, fault and write strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 read by address, 1 write by address, 2 read by index, 3 reserved |
| req_addr | input | ADDR_W | Window and counter number for address ops |
| req_index | input | 32 | Counter index for op 2 (bit 31 fast, bit 30 fixed bank) |
| req_wdata | input | 64 | Write data |
| rsp_ack | output | 1 | One-cycle acknowledge |
| rsp_fault | output | 1 | Access was illegal |
| rsp_rdata | output | 64 | Read result, zero on writes and faults |
| st_rd_fixed | output | 1 | Storage read selects the fixed bank |
| st_rd_idx | output | IDX_W | Storage read counter number |
| st_rd_data | input | 64 | Storage read data, same cycle |
| st_wr_en | output | 1 | Storage write strobe |
| st_wr_fixed | output | 1 | Storage write targets the fixed bank |
| st_wr_idx | output | IDX_W | Storage write counter number |
| st_wr_data | output | 64 | Storage write value |

## Verification
The bench sweeps every counter in both banks through every window and both read-index flavours. Expected values come from its own sign-extension and masking arithmetic. It targets the sign-extension boundary at bit 31: a design that zero-extends would store 0x0000_8000_0000 where 0xFFFF_8000_0000 is due. It also targets the over-width edge at exactly bit 48: an off-by-one compare would accept that write silently, or would reject the all-ones 48-bit value. The count limits are probed one past the last counter in each bank and at index 64. There a weak compare would alias onto a real counter and return its data instead of faulting. After every fault, a readback shows that the counter kept its old value.

// File: rtl/cap_pkg.sv
// Shared types and helpers for the counter access port.
package cap_pkg;

    // Request operations carried on req_op.
    typedef enum logic [1:0] {
        OP_RD_ADDR = 2'd0,
        OP_WR_ADDR = 2'd1,
        OP_RD_IDX  = 2'd2,
        OP_RSVD    = 2'd3
    } cap_op_e;

    // Address windows after decode.
    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_LEGACY = 2'd1,
        WIN_FULL   = 2'd2,
        WIN_FIXED  = 2'd3
    } cap_win_e;

    // Mask with the low w bits set; a shift of 64 yields all ones.
    function automatic logic [63:0] low_mask(int w);
        return (64'd1 << w) - 64'd1;
    endfunction

endpackage

// File: rtl/cap_addr_decode.sv
// Address decoder: splits an access address into window and counter number.
// Assumes the window number sits above WIN_SHIFT and the counter number below it.
module cap_addr_decode #(
    parameter int ADDR_W    = 12,
    parameter int WIN_SHIFT = 8,
    parameter int NUM_GP    = 4,
    parameter int NUM_FIX   = 3,
    parameter int IDX_W     = 2,
    parameter int LEG_WIN   = 1,
    parameter int FULL_WIN  = 2,
    parameter int FIX_WIN   = 3
) (
    input  logic [ADDR_W-1:0]   addr,
    output cap_pkg::cap_win_e   win,
    output logic                in_range,
    output logic [IDX_W-1:0]    idx
);
    localparam int WSEL_W = ADDR_W - WIN_SHIFT;
    localparam logic [WSEL_W-1:0]    LEG_SEL  = WSEL_W'(LEG_WIN);
    localparam logic [WSEL_W-1:0]    FULL_SEL = WSEL_W'(FULL_WIN);
    localparam logic [WSEL_W-1:0]    FIX_SEL  = WSEL_W'(FIX_WIN);
    localparam logic [WIN_SHIFT-1:0] GP_LIM   = WIN_SHIFT'(NUM_GP);
    localparam logic [WIN_SHIFT-1:0] FIX_LIM  = WIN_SHIFT'(NUM_FIX);

    logic [WSEL_W-1:0]    wsel;
    logic [WIN_SHIFT-1:0] num;

    assign wsel = addr[ADDR_W-1:WIN_SHIFT];
    assign num  = addr[WIN_SHIFT-1:0];
    assign idx  = num[IDX_W-1:0];

    // Window lookup and bank-size range check.
    always_comb begin
        win      = cap_pkg::WIN_NONE;
        in_range = 1'b0;
        if (wsel == LEG_SEL) begin
            win      = cap_pkg::WIN_LEGACY;
            in_range = num < GP_LIM;
        end else if (wsel == FULL_SEL) begin
            win      = cap_pkg::WIN_FULL;
            in_range = num < GP_LIM;
        end else if (wsel == FIX_SEL) begin
            win      = cap_pkg::WIN_FIXED;
            in_range = num < FIX_LIM;
        end
    end
endmodule

// File: rtl/cap_index_decode.sv
// Read-index decoder: bit 31 asks for a 32-bit read, bit 30 picks the fixed
// bank, bits [29:0] hold the counter number. Assumes a 32-bit index.
module cap_index_decode #(
    parameter int NUM_GP  = 4,
    parameter int NUM_FIX = 3,
    parameter int IDX_W   = 2
) (
    input  logic [31:0]      index,
    output logic             fast,
    output logic             fixed,
    output logic             in_range,
    output logic [IDX_W-1:0] idx
);
    localparam logic [29:0] GP_LIM  = 30'(NUM_GP);
    localparam logic [29:0] FIX_LIM = 30'(NUM_FIX);

    logic [29:0] num;

    assign num   = index[29:0];
    assign fast  = index[31];
    assign fixed = index[30];
    assign idx   = num[IDX_W-1:0];

    // Range check against the selected bank's count.
    always_comb begin
        in_range = fixed ? (num < FIX_LIM) : (num < GP_LIM);
    end
endmodule

// File: rtl/cap_write_shaper.sv
// Write shaper: turns raw write data into the value to store, for the window
// that was hit, and flags values wider than the target counter.
// Assumes widths between 1 and 64.
module cap_write_shaper #(
    parameter int GP_W  = 48,
    parameter int FIX_W = 48
) (
    input  cap_pkg::cap_win_e win,
    input  logic [63:0]       wdata,
    output logic [63:0]       value,
    output logic              over
);
    localparam logic [63:0] GP_MASK  = cap_pkg::low_mask(GP_W);
    localparam logic [63:0] FIX_MASK = cap_pkg::low_mask(FIX_W);

    logic [63:0] sext32;

    assign sext32 = {{32{wdata[31]}}, wdata[31:0]};

    // Per-window value shaping and over-width detection.
    always_comb begin
        value = '0;
        over  = 1'b0;
        unique case (win)
            cap_pkg::WIN_LEGACY: value = sext32 & GP_MASK;
            cap_pkg::WIN_FULL: begin
                value = wdata & GP_MASK;
                over  = |(wdata & ~GP_MASK);
            end
            cap_pkg::WIN_FIXED: begin
                value = wdata & FIX_MASK;
                over  = |(wdata & ~FIX_MASK);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cap_top.sv
// Counter access port: decodes address and index accesses to a counter bank
// held outside the block, shapes write values, masks read data, and answers
// each request one cycle later with ack and, when illegal, fault.
// Assumes storage read data is valid in the cycle the read selector is driven.
module cap_top #(
    parameter int ADDR_W    = 12,
    parameter int WIN_SHIFT = 8,
    parameter int NUM_GP    = 4,
    parameter int NUM_FIX   = 3,
    parameter int GP_W      = 48,
    parameter int FIX_W     = 48,
    localparam int MAX_N    = (NUM_GP > NUM_FIX) ? NUM_GP : NUM_FIX,
    localparam int IDX_W    = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_index,
    input  logic [63:0]       req_wdata,
    output logic              rsp_ack,
    output logic              rsp_fault,
    output logic [63:0]       rsp_rdata,
    output logic              st_rd_fixed,
    output logic [IDX_W-1:0]  st_rd_idx,
    input  logic [63:0]       st_rd_data,
    output logic              st_wr_en,
    output logic              st_wr_fixed,
    output logic [IDX_W-1:0]  st_wr_idx,
    output logic [63:0]       st_wr_data
);
    import cap_pkg::*;

    localparam logic [63:0] GP_MASK  = low_mask(GP_W);
    localparam logic [63:0] FIX_MASK = low_mask(FIX_W);

    cap_op_e          op;
    cap_win_e         ad_win;
    logic             ad_ok;
    logic [IDX_W-1:0] ad_idx;
    logic             ix_fast, ix_fixed, ix_ok;
    logic [IDX_W-1:0] ix_idx;
    logic [63:0]      wr_value;
    logic             wr_over;
    logic [63:0]      rd_mask;
    logic             fault_c, wr_c;
    logic [63:0]      rdata_c;

    assign op = cap_op_e'(req_op);

    cap_addr_decode #(
        .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .NUM_GP(NUM_GP),
        .NUM_FIX(NUM_FIX), .IDX_W(IDX_W), .LEG_WIN(1), .FULL_WIN(2), .FIX_WIN(3)
    ) u_addr (
        .addr(req_addr), .win(ad_win), .in_range(ad_ok), .idx(ad_idx)
    );

    cap_index_decode #(
        .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .IDX_W(IDX_W)
    ) u_index (
        .index(req_index), .fast(ix_fast), .fixed(ix_fixed),
        .in_range(ix_ok), .idx(ix_idx)
    );

    cap_write_shaper #(
        .GP_W(GP_W), .FIX_W(FIX_W)
    ) u_shape (
        .win(ad_win), .wdata(req_wdata), .value(wr_value), .over(wr_over)
    );

    // Storage read selector: the index path for op 2, the address path otherwise.
    always_comb begin
        if (op == OP_RD_IDX) begin
            st_rd_fixed = ix_fixed;
            st_rd_idx   = ix_idx;
        end else begin
            st_rd_fixed = (ad_win == WIN_FIXED);
            st_rd_idx   = ad_idx;
        end
    end

    // Read mask: one shared mask when both banks have the same width.
    generate
        if (GP_W == FIX_W) begin : g_mask_shared
            assign rd_mask = GP_MASK;
        end else begin : g_mask_split
            assign rd_mask = st_rd_fixed ? FIX_MASK : GP_MASK;
        end
    endgenerate

    // Legality, write decision and read data for the current request.
    always_comb begin
        fault_c = 1'b0;
        wr_c    = 1'b0;
        rdata_c = '0;
        unique case (op)
            OP_RD_ADDR: begin
                fault_c = !ad_ok;
                rdata_c = st_rd_data & rd_mask;
            end
            OP_WR_ADDR: begin
                fault_c = !ad_ok || wr_over;
                wr_c    = !fault_c;
            end
            OP_RD_IDX: begin
                fault_c = !ix_ok;
                rdata_c = st_rd_data & rd_mask;
                if (ix_fast) rdata_c[63:32] = '0;
            end
            default: fault_c = 1'b1;
        endcase
        if (fault_c) rdata_c = '0;
    end

    // Response and write-strobe registers, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_ack     <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_rdata   <= '0;
            st_wr_en    <= 1'b0;
            st_wr_fixed <= 1'b0;
            st_wr_idx   <= '0;
            st_wr_data  <= '0;
        end else begin
            rsp_ack     <= req_valid;
            rsp_fault   <= req_valid && fault_c;
            rsp_rdata   <= req_valid ? rdata_c : '0;
            st_wr_en    <= req_valid && wr_c;
            st_wr_fixed <= (ad_win == WIN_FIXED);
            st_wr_idx   <= ad_idx;
            st_wr_data  <= wr_value;
        end
    end

    // R8: a fault always rides on an acknowledge.
    a_r8_fault_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_ack);

    // R8: a faulting response carries zero data.
    a_r8_fault_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_rdata == 64'd0));

    // R8: a faulting response never comes with a storage write.
    a_r8_fault_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> !st_wr_en);

    // R9: each request is answered in the next cycle.
    a_r9_req_gets_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ack);

    // R9: no acknowledge without a request in the cycle before.
    a_r9_ack_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ack |-> $past(req_valid));

    // R3: no general-purpose write carries bits beyond the counter width.
    a_r3_no_wide_store: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && !st_wr_fixed) |-> ((st_wr_data & ~GP_MASK) == 64'd0));

    // R6: a fast index read returns zero in the upper half.
    a_r6_fast_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ack && $past(req_op == 2'd2 && req_index[31])) |-> (rsp_rdata[63:32] == 32'd0));
endmodule

// File: tb/cap_top_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps all counters through every window and read flavour, with a
// storage array standing in for the counter bank.
module cap_top_tb_top;
    localparam int NG = 4;
    localparam int NF = 3;
    localparam logic [63:0] M48 = 64'h0000_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_index = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_ack, rsp_fault;
    logic [63:0] rsp_rdata;
    logic        st_rd_fixed, st_wr_en, st_wr_fixed;
    logic [1:0]  st_rd_idx, st_wr_idx;
    logic [63:0] st_rd_data, st_wr_data;

    logic [63:0] gp_mem [4];
    logic [63:0] fx_mem [4];
    logic [63:0] gp_exp [NG];
    logic [63:0] fx_exp [NF];

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cap_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_index(req_index), .req_wdata(req_wdata),
        .rsp_ack(rsp_ack), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .st_rd_fixed(st_rd_fixed), .st_rd_idx(st_rd_idx), .st_rd_data(st_rd_data),
        .st_wr_en(st_wr_en), .st_wr_fixed(st_wr_fixed), .st_wr_idx(st_wr_idx),
        .st_wr_data(st_wr_data)
    );

    // Counter storage model.
    always_comb st_rd_data = st_rd_fixed ? fx_mem[st_rd_idx] : gp_mem[st_rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 4; k++) begin
                gp_mem[k] <= '0;
                fx_mem[k] <= '0;
            end
        end else if (st_wr_en) begin
            if (st_wr_fixed) fx_mem[st_wr_idx] <= st_wr_data;
            else             gp_mem[st_wr_idx] <= st_wr_data;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic        r_ack, r_fault;
    logic [63:0] r_data;

    // One request, response sampled one cycle later; also checks the ack pulse ends.
    task automatic xfer(input logic [1:0] op, input logic [11:0] addr,
                        input logic [31:0] index, input logic [63:0] wdata);
        @(negedge clk);
        req_op = op; req_addr = addr; req_index = index; req_wdata = wdata;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        r_ack = rsp_ack; r_fault = rsp_fault; r_data = rsp_rdata;
        @(negedge clk);
        chk("R9 ack once", {63'd0, r_ack & ~rsp_ack}, 64'd1);
    endtask

    function automatic logic [63:0] legacy_val(input logic [63:0] v);
        return {{32{v[31]}}, v[31:0]} & M48;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 ack in reset", {63'd0, rsp_ack}, 64'd0);
        chk("R11 fault in reset", {63'd0, rsp_fault}, 64'd0);
        chk("R11 write in reset", {63'd0, st_wr_en}, 64'd0);
        rst_n = 1'b1;
        for (int i = 0; i < NG; i++) gp_exp[i] = '0;
        for (int j = 0; j < NF; j++) fx_exp[j] = '0;

        for (int i = 0; i < NG; i++) begin
            logic [63:0] v;
            // Negative 32-bit value: sign extension into bits 47:32.
            v = 64'hDEAD_0000_8000_0000 | 64'(i * 'h111);
            xfer(2'd1, 12'h100 + 12'(i), 32'd0, v);
            chk("R1 legacy neg no fault", {63'd0, r_fault}, 64'd0);
            gp_exp[i] = legacy_val(v);
            xfer(2'd0, 12'h100 + 12'(i), 32'd0, 64'd0);
            chk("R4 read legacy window", r_data, gp_exp[i]);
            xfer(2'd0, 12'h200 + 12'(i), 32'd0, 64'd0);
            chk("R4 read full window", r_data, gp_exp[i]);
            xfer(2'd2, 12'h0, 32'(i), 64'd0);
            chk("R5 index read gp", r_data, gp_exp[i]);
            xfer(2'd2, 12'h0, 32'h8000_0000 | 32'(i), 64'd0);
            chk("R6 fast read gp", r_data, {32'd0, gp_exp[i][31:0]});

            // Positive 32-bit value with garbage above bit 31.
            v = 64'hFFFF_FFFF_1234_5678 + 64'(i);
            xfer(2'd1, 12'h100 + 12'(i), 32'd0, v);
            chk("R1 legacy upper ignored", {63'd0, r_fault}, 64'd0);
            gp_exp[i] = legacy_val(v);
            xfer(2'd2, 12'h0, 32'(i), 64'd0);
            chk("R1 legacy positive", r_data, gp_exp[i]);

            // Full-width value inside 48 bits.
            v = 64'h0000_ABCD_0123_4567 ^ 64'(i);
            xfer(2'd1, 12'h200 + 12'(i), 32'd0, v);
            chk("R2 full write ok", {63'd0, r_fault}, 64'd0);
            gp_exp[i] = v;
            xfer(2'd0, 12'h200 + 12'(i), 32'd0, 64'd0);
            chk("R2 full readback", r_data, gp_exp[i]);

            // Over-width writes fault and leave the counter alone.
            xfer(2'd1, 12'h200 + 12'(i), 32'd0, 64'hFFFF_FF01_2345_6789);
            chk("R3 over-width fault", {63'd0, r_fault}, 64'd1);
            chk("R8 fault data zero", r_data, 64'd0);
            chk("R8 fault with ack", {63'd0, r_ack}, 64'd1);
            xfer(2'd1, 12'h200 + 12'(i), 32'd0, 64'h0001_0000_0000_0000);
            chk("R3 bit48 fault", {63'd0, r_fault}, 64'd1);
            xfer(2'd0, 12'h100 + 12'(i), 32'd0, 64'd0);
            chk("R3 counter unchanged", r_data, gp_exp[i]);
            xfer(2'd1, 12'h200 + 12'(i), 32'd0, M48);
            chk("R2 max width ok", {63'd0, r_fault}, 64'd0);
            gp_exp[i] = M48;
            xfer(2'd2, 12'h0, 32'(i), 64'd0);
            chk("R2 max width readback", r_data, M48);
        end

        for (int j = 0; j < NF; j++) begin
            logic [63:0] v;
            v = (64'hFF01_2345_6789 & M48) + 64'(j);
            xfer(2'd1, 12'h300 + 12'(j), 32'd0, v);
            chk("R10 fixed write ok", {63'd0, r_fault}, 64'd0);
            fx_exp[j] = v;
            xfer(2'd2, 12'h0, 32'h4000_0000 | 32'(j), 64'd0);
            chk("R10 fixed index read", r_data, fx_exp[j]);
            xfer(2'd2, 12'h0, 32'hC000_0000 | 32'(j), 64'd0);
            chk("R6 fixed fast read", r_data, {32'd0, fx_exp[j][31:0]});
            xfer(2'd1, 12'h300 + 12'(j), 32'd0, 64'hFFFF_FF01_2345_6789);
            chk("R10 fixed over-width fault", {63'd0, r_fault}, 64'd1);
            xfer(2'd0, 12'h300 + 12'(j), 32'd0, 64'd0);
            chk("R10 fixed unchanged", r_data, fx_exp[j]);
        end

        // Illegal accesses.
        xfer(2'd2, 12'h0, 32'd64, 64'd0);
        chk("R7 index 64 fault", {63'd0, r_fault}, 64'd1);
        chk("R8 index 64 data", r_data, 64'd0);
        xfer(2'd2, 12'h0, 32'd4, 64'd0);
        chk("R7 gp index past end", {63'd0, r_fault}, 64'd1);
        xfer(2'd2, 12'h0, 32'h4000_0003, 64'd0);
        chk("R7 fixed index past end", {63'd0, r_fault}, 64'd1);
        xfer(2'd1, 12'h104, 32'd0, 64'd5);
        chk("R7 legacy addr past end", {63'd0, r_fault}, 64'd1);
        xfer(2'd1, 12'h303, 32'd0, 64'd5);
        chk("R7 fixed addr past end", {63'd0, r_fault}, 64'd1);
        xfer(2'd0, 12'h000, 32'd0, 64'd0);
        chk("R7 no window fault", {63'd0, r_fault}, 64'd1);
        xfer(2'd3, 12'h100, 32'd0, 64'd0);
        chk("R7 reserved op fault", {63'd0, r_fault}, 64'd1);
        for (int i = 0; i < NG; i++) begin
            xfer(2'd2, 12'h0, 32'(i), 64'd0);
            chk("R8 no write by faults gp", r_data, gp_exp[i]);
        end
        for (int j = 0; j < NF; j++) begin
            xfer(2'd2, 12'h0, 32'h4000_0000 | 32'(j), 64'd0);
            chk("R8 no write by faults fixed", r_data, fx_exp[j]);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule